// File: doc/BRIEF.md
# PCM Time-Division Slot Mapper

This block places two voice channels on a framed PCM serial bus. A bit counter runs on the bus bit clock and is realigned by a one-cycle frame sync pulse. Each frame is divided into slots of eight bit periods. Each channel owns one slot, which is used for both transmit and receive. During that slot the channel's sample goes out MSB first on the serial output, with its output-enable strobe high. The matching bits from the serial input are gathered into a receive word.

A single write-only control byte programs the slots. One bit turns custom placement on. One bit picks the channel that the 6-bit slot field applies to, so setting both channels takes two writes. While custom placement is off, a fixed mapping applies. A mode input selects 8-bit companded samples or 14-bit linear samples. A linear sample spans two adjacent slots and starts on an even slot. Companding, the analog front end and clock generation are outside this block.

Top module: `pcm_slot_mapper`

## Requirements
- R1: After reset, and until the first frame sync is sampled, `pcmOutEn`, `ch1RxValid` and `ch2RxValid` stay low.
- R2: The bit counter becomes 0 on the clock edge that samples `frameSync` high, so the following cycle is bit 0 of slot 0. Without a new sync, the counter wraps to 0 after NUM_SLOTS*8 bits.
- R3: A control write (`ctlWrEn` high at a clock edge) sets the custom-enable flag from bit 7. It stores bits 5:0 as the slot of the channel chosen by bit 6 (0 = channel 1, 1 = channel 2). The other channel's stored slot is left unchanged.
- R4: While the custom-enable flag is 0, channel 1 uses slot 0 and channel 2 uses slot 2. Stored slots are kept but ignored, and they apply again once a write sets bit 7.
- R5: In companded mode (`linearMode` = 0) a channel's window is the 8 bits starting at bit slot*8. In the window, `pcmOutEn` is high and `pcmOut` carries Tx bits 7 down to 0.
- R6: In linear mode (`linearMode` = 1) the window is the 16 bits starting at bit slot*8. `pcmOut` carries Tx bits 13 down to 0 and then two 0 padding bits, with `pcmOutEn` high for all 16.
- R7: A slot written while `linearMode` is 1 is stored with bit 0 cleared.
- R8: `pcmIn` is sampled at the end of every data bit of a channel's window. After the window's last bit, the Rx word is updated and RxValid is high for exactly one cycle. A companded Rx word is the 8 received bits, zero-extended. A linear Rx word is the 14 received bits, and the padding bits are ignored.
- R9: A channel whose window would extend past the end of the frame never drives, captures or raises RxValid.
- R10: When the two windows overlap, channel 1 is served and channel 2 is silent for the whole frame, with no enable, capture or RxValid.
- R11: `pcmOut` is 0 whenever `pcmOutEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame alignment pulse |
| ctlWrEn | input | 1 | Control byte write strobe |
| ctlWrData | input | 8 | Control byte: [7] custom enable, [6] channel, [5:0] slot |
| linearMode | input | 1 | 1 = 14-bit linear, 0 = 8-bit companded |
| ch1Tx | input | 14 | Channel 1 transmit sample |
| ch2Tx | input | 14 | Channel 2 transmit sample |
| pcmIn | input | 1 | Serial receive data |
| pcmOut | output | 1 | Serial transmit data |
| pcmOutEn | output | 1 | Drive enable for the serial output |
| ch1Rx | output | 14 | Channel 1 received sample |
| ch2Rx | output | 14 | Channel 2 received sample |
| ch1RxValid | output | 1 | Channel 1 receive word strobe |
| ch2RxValid | output | 1 | Channel 2 receive word strobe |

## Verification
The bench builds the block with NUM_SLOTS = 8, which gives a 64-bit frame. That is short enough to sweep every pairing of the two channel slots in both sample modes, including every collision and every odd slot written in linear mode. Because the slot field reaches 63, most of its codes lie past this short frame, so the silent out-of-frame case can be reached directly. The final linear slot, whose window ends exactly at the frame boundary, is also exercised.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int SLOT_FIELD_W  = 6;
  localparam int BITS_PER_SLOT = 8;
  localparam int SAMPLE_W      = 14;
  localparam int IDX_W         = 4;

  typedef struct packed {
    logic             framed;
    logic             ch1Act;
    logic             ch2Act;
    logic [IDX_W-1:0] idx1;
    logic [IDX_W-1:0] idx2;
    logic             ch1Last;
    logic             ch2Last;
  } slotStrobes_t;
endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameSync,
  input  logic         ctlWrEn,
  input  logic [7:0]   ctlWrData,
  input  logic         linearMode,
  output slotStrobes_t strobes
);
  localparam int FRAME_BITS = NUM_SLOTS * BITS_PER_SLOT;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int BASE_W     = (CNT_W > SLOT_FIELD_W + 3) ? CNT_W : SLOT_FIELD_W + 3;
  localparam int WIN_W      = BASE_W + 2;

  logic             customEn;
  logic             framed;
  logic [CNT_W-1:0] bitCnt;
  logic [WIN_W-1:0] cntW;
  logic [WIN_W-1:0] winLen;
  logic [WIN_W-1:0] winStart [2];
  logic [WIN_W-1:0] winEnd   [2];
  logic [1:0]       fits;
  logic [1:0]       inWin;
  logic [1:0]       isLast;
  logic [IDX_W-1:0] idx [2];
  logic             collide;

  // frame bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      framed <= 1'b0;
    end else if (frameSync) begin
      bitCnt <= '0;
      framed <= 1'b1;
    end else if (bitCnt == CNT_W'(FRAME_BITS - 1)) begin
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        customEn <= 1'b0;
    else if (ctlWrEn) customEn <= ctlWrData[7];
  end

  assign cntW   = WIN_W'(bitCnt);
  assign winLen = linearMode ? WIN_W'(2 * BITS_PER_SLOT) : WIN_W'(BITS_PER_SLOT);

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam logic [SLOT_FIELD_W-1:0] DEF_SLOT = (ch == 0) ? SLOT_FIELD_W'(0) : SLOT_FIELD_W'(2);
    logic [SLOT_FIELD_W-1:0] slotReg;
    logic [SLOT_FIELD_W-1:0] effSlot;

    always_ff @(posedge clk) begin
      if (!rstN)
        slotReg <= '0;
      else if (ctlWrEn && (ctlWrData[6] == 1'(ch)))
        slotReg <= {ctlWrData[SLOT_FIELD_W-1:1], ctlWrData[0] & ~linearMode};
    end

    assign effSlot     = customEn ? slotReg : DEF_SLOT;
    assign winStart[ch] = WIN_W'(effSlot) << 3;
    assign winEnd[ch]   = winStart[ch] + winLen;
    assign fits[ch]     = winEnd[ch] <= WIN_W'(FRAME_BITS);
    assign inWin[ch]    = framed && fits[ch] && (cntW >= winStart[ch]) && (cntW < winEnd[ch]);
    assign idx[ch]      = IDX_W'(cntW - winStart[ch]);
    assign isLast[ch]   = inWin[ch] && (idx[ch] == (linearMode ? IDX_W'(15) : IDX_W'(7)));

    // R7: odd slot written in linear mode is stored even
    p_lin_even_r7: assert property (@(posedge clk) disable iff (!rstN)
      ctlWrEn && linearMode && (ctlWrData[6] == 1'(ch)) |=> (slotReg[0] == 1'b0));
  end

  assign collide = fits[0] && fits[1] &&
                   (winStart[0] < winEnd[1]) && (winStart[1] < winEnd[0]);

  always_comb begin
    strobes         = '0;
    strobes.framed  = framed;
    strobes.ch1Act  = inWin[0];
    strobes.ch2Act  = inWin[1] && !collide;
    strobes.idx1    = idx[0];
    strobes.idx2    = idx[1];
    strobes.ch1Last = isLast[0];
    strobes.ch2Last = isLast[1] && !collide;
  end

  // R2, R4: sync with default mapping starts channel 1 bit 0 next cycle
  p_slot0_after_sync_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameSync && !ctlWrEn && !customEn |=> strobes.ch1Act && (strobes.idx1 == '0));

  // R10: never two channels on the line at once
  p_ch_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.ch1Act && strobes.ch2Act));
endmodule

// File: rtl/pcm_slot_datapath.sv
module pcm_slot_datapath
  import pcm_slot_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  slotStrobes_t                 strobes,
  input  logic                         linearMode,
  input  logic [1:0][SAMPLE_W-1:0]     txWord,
  input  logic                         pcmIn,
  output logic                         pcmOut,
  output logic                         pcmOutEn,
  output logic [1:0][SAMPLE_W-1:0]     rxWord,
  output logic [1:0]                   rxValid
);
  logic [1:0]            act;
  logic [1:0]            last;
  logic [1:0][IDX_W-1:0] idx;
  logic [1:0]            txBit;

  assign act  = {strobes.ch2Act, strobes.ch1Act};
  assign last = {strobes.ch2Last, strobes.ch1Last};
  assign idx  = {strobes.idx2, strobes.idx1};

  function automatic logic pickBit(input logic [SAMPLE_W-1:0] w,
                                   input logic [IDX_W-1:0] i, input logic lin);
    logic [IDX_W-1:0] sel;
    logic             b;
    if (lin) begin
      sel = IDX_W'(SAMPLE_W - 1) - i;
      b   = (i < IDX_W'(SAMPLE_W)) ? w[sel] : 1'b0;
    end else begin
      sel = IDX_W'(7) - i;
      b   = (i < IDX_W'(8)) ? w[sel] : 1'b0;
    end
    return b;
  endfunction

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    logic [SAMPLE_W-1:0] shReg;
    logic [SAMPLE_W-1:0] rxReg;
    logic                vReg;
    logic                capture;

    assign txBit[ch] = pickBit(txWord[ch], idx[ch], linearMode);
    assign capture   = act[ch] && (!linearMode || (idx[ch] < IDX_W'(SAMPLE_W)));

    always_ff @(posedge clk) begin
      if (!rstN)        shReg <= '0;
      else if (capture) shReg <= {shReg[SAMPLE_W-2:0], pcmIn};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxReg <= '0;
        vReg  <= 1'b0;
      end else begin
        vReg <= last[ch];
        if (last[ch])
          rxReg <= linearMode ? shReg : {{(SAMPLE_W-8){1'b0}}, shReg[6:0], pcmIn};
      end
    end

    assign rxWord[ch]  = rxReg;
    assign rxValid[ch] = vReg;

    // R8: a word strobe follows every window end, and only a window end
    p_valid_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
      last[ch] |=> rxValid[ch]);
    p_valid_needs_last_r8: assert property (@(posedge clk) disable iff (!rstN)
      rxValid[ch] |-> $past(last[ch]));
  end

  assign pcmOutEn = |act;
  assign pcmOut   = act[0] ? txBit[0] : (act[1] ? txBit[1] : 1'b0);

  // R1: nothing leaves the block before frame alignment
  p_unframed_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.framed |-> !pcmOutEn && (rxValid == 2'b00));
endmodule

// File: rtl/pcm_slot_mapper.sv
module pcm_slot_mapper
  import pcm_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 64
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                frameSync,
  input  logic                ctlWrEn,
  input  logic [7:0]          ctlWrData,
  input  logic                linearMode,
  input  logic [SAMPLE_W-1:0] ch1Tx,
  input  logic [SAMPLE_W-1:0] ch2Tx,
  input  logic                pcmIn,
  output logic                pcmOut,
  output logic                pcmOutEn,
  output logic [SAMPLE_W-1:0] ch1Rx,
  output logic [SAMPLE_W-1:0] ch2Rx,
  output logic                ch1RxValid,
  output logic                ch2RxValid
);
  slotStrobes_t              strobes;
  logic [1:0][SAMPLE_W-1:0]  rxWord;
  logic [1:0]                rxValid;

  pcm_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk        (bitClk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .ctlWrEn    (ctlWrEn),
    .ctlWrData  (ctlWrData),
    .linearMode (linearMode),
    .strobes    (strobes)
  );

  pcm_slot_datapath u_dp (
    .clk        (bitClk),
    .rstN       (rstN),
    .strobes    (strobes),
    .linearMode (linearMode),
    .txWord     ({ch2Tx, ch1Tx}),
    .pcmIn      (pcmIn),
    .pcmOut     (pcmOut),
    .pcmOutEn   (pcmOutEn),
    .rxWord     (rxWord),
    .rxValid    (rxValid)
  );

  assign ch1Rx      = rxWord[0];
  assign ch2Rx      = rxWord[1];
  assign ch1RxValid = rxValid[0];
  assign ch2RxValid = rxValid[1];
endmodule

// File: tb/pcm_slot_mapper_test.sv
module pcm_slot_mapper_test;
  localparam int NS = 8;
  localparam int FB = NS * 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameSync;
  logic        ctlWrEn;
  logic [7:0]  ctlWrData;
  logic        linearMode;
  logic [13:0] ch1Tx, ch2Tx;
  logic        pcmIn;
  logic        pcmOut, pcmOutEn;
  logic [13:0] ch1Rx, ch2Rx;
  logic        ch1RxValid, ch2RxValid;

  always #2 clk = ~clk;

  pcm_slot_mapper #(.NUM_SLOTS(NS)) uut (
    .bitClk(clk), .rstN(rstN), .frameSync(frameSync), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .linearMode(linearMode), .ch1Tx(ch1Tx), .ch2Tx(ch2Tx),
    .pcmIn(pcmIn), .pcmOut(pcmOut), .pcmOutEn(pcmOutEn), .ch1Rx(ch1Rx),
    .ch2Rx(ch2Rx), .ch1RxValid(ch1RxValid), .ch2RxValid(ch2RxValid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mEn = 0;
  int mLin = 0;
  int mSlot [2] = '{0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effSlot(input int ch);
    return (mEn != 0) ? mSlot[ch] : ((ch == 0) ? 0 : 2);
  endfunction
  function automatic int winLen();
    return (mLin != 0) ? 16 : 8;
  endfunction
  function automatic bit fits(input int ch);
    return effSlot(ch) * 8 + winLen() <= FB;
  endfunction
  function automatic bit collide();
    int s0 = effSlot(0) * 8;
    int s1 = effSlot(1) * 8;
    return fits(0) && fits(1) && (s0 < s1 + winLen()) && (s1 < s0 + winLen());
  endfunction
  function automatic bit inWin(input int ch, input int b);
    int s = effSlot(ch) * 8;
    return fits(ch) && (b >= s) && (b < s + winLen()) && ((ch == 0) || !collide());
  endfunction
  function automatic int pinBit(input int b, input int seed);
    return (((b * 13 + seed) >> 1) ^ b ^ (seed >> 3)) & 1;
  endfunction
  function automatic int txBitOf(input logic [13:0] t, input int o);
    if (mLin != 0) return (o < 14) ? int'(t[13 - o]) : 0;
    return int'(t[7 - o]);
  endfunction

  task automatic wr(input logic [7:0] d);
    int s;
    ctlWrData = d;
    ctlWrEn   = 1'b1;
    @(negedge clk);
    ctlWrEn = 1'b0;
    mEn = int'(d[7]);
    s   = int'(d[5:0]);
    if (mLin != 0) s = s & 62;
    mSlot[int'(d[6])] = s;
  endtask

  task automatic sampValid(input int expRx [2], inout int got [2], input string tag);
    for (int ch = 0; ch < 2; ch++) begin
      logic        v = (ch == 0) ? ch1RxValid : ch2RxValid;
      logic [13:0] r = (ch == 0) ? ch1Rx : ch2Rx;
      if (v) begin
        got[ch]++;
        chk(int'(r) == expRx[ch], $sformatf("R8 %s rx word ch%0d", tag, ch + 1), int'(r), expRx[ch]);
      end
    end
  endtask

  task automatic runFrame(input bit doSync, input int seed, input string tag);
    logic [13:0] t [2];
    int expRx [2];
    int expCnt [2];
    int got [2];
    t[0] = 14'(seed * 40503 + 4951);
    t[1] = 14'(seed * 9973 + 777);
    ch1Tx = t[0];
    ch2Tx = t[1];
    for (int ch = 0; ch < 2; ch++) begin
      int nData = (mLin != 0) ? 14 : 8;
      expRx[ch] = 0;
      expCnt[ch] = 0;
      got[ch] = 0;
      for (int b = 0; b < FB; b++) begin
        if (inWin(ch, b)) begin
          expCnt[ch] = 1;
          if (b - effSlot(ch) * 8 < nData) expRx[ch] = (expRx[ch] << 1) | pinBit(b, seed);
        end
      end
    end
    if (doSync) begin
      frameSync = 1'b1;
      @(negedge clk);
      frameSync = 1'b0;
    end
    for (int b = 0; b < FB; b++) begin
      int e1 = int'(inWin(0, b));
      int e2 = int'(inWin(1, b));
      int expEn = e1 | e2;
      int expOut = (e1 != 0) ? txBitOf(t[0], b - effSlot(0) * 8)
                 : (e2 != 0) ? txBitOf(t[1], b - effSlot(1) * 8) : 0;
      chk(int'(pcmOutEn) == expEn, $sformatf("%s bit %0d enable", tag, b), int'(pcmOutEn), expEn);
      chk(int'(pcmOut) == expOut,
          (expEn != 0) ? $sformatf("%s bit %0d data", tag, b) : $sformatf("R11 idle line bit %0d", b),
          int'(pcmOut), expOut);
      pcmIn = 1'(pinBit(b, seed));
      if (b > 0) sampValid(expRx, got, tag);
      @(negedge clk);
    end
    sampValid(expRx, got, tag);
    for (int ch = 0; ch < 2; ch++)
      chk(got[ch] == expCnt[ch], $sformatf("R8 %s strobe count ch%0d", tag, ch + 1), got[ch], expCnt[ch]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameSync = 1'b0; ctlWrEn = 1'b0; ctlWrData = '0;
    linearMode = 1'b0; ch1Tx = '0; ch2Tx = '0; pcmIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet until first sync
    for (int i = 0; i < 12; i++) begin
      chk(!pcmOutEn && !ch1RxValid && !ch2RxValid, "R1 before first sync", int'(pcmOutEn), 0);
      chk(pcmOut == 1'b0, "R11 line before sync", int'(pcmOut), 0);
      @(negedge clk);
    end

    // R4, R5: default mapping companded; R2 wrap without sync
    runFrame(1'b1, 1, "R4 R5 default companded");
    runFrame(1'b0, 2, "R2 wrap without sync");
    repeat (13) @(negedge clk);
    runFrame(1'b1, 3, "R2 realign after idle");

    // R6: default mapping linear
    linearMode = 1'b1; mLin = 1;
    runFrame(1'b1, 4, "R4 R6 default linear");
    linearMode = 1'b0; mLin = 0;

    // R5, R10: every slot pair companded
    for (int s1 = 0; s1 < NS; s1++)
      for (int s2 = 0; s2 < NS; s2++) begin
        wr(8'h80 | 8'(s1));
        wr(8'hC0 | 8'(s2));
        runFrame(1'b1, 10 + s1 * NS + s2, "R3 R5 R10 companded sweep");
      end

    // R6, R7, R10: every written slot pair linear (odd writes become even)
    linearMode = 1'b1; mLin = 1;
    for (int s1 = 0; s1 < NS; s1++)
      for (int s2 = 0; s2 < NS; s2++) begin
        wr(8'h80 | 8'(s1));
        wr(8'hC0 | 8'(s2));
        runFrame(1'b1, 200 + s1 * NS + s2, "R6 R7 R10 linear sweep");
      end

    // R9: windows past frame end
    wr(8'h80 | 8'd63); wr(8'hC0 | 8'd6);
    runFrame(1'b1, 300, "R9 linear ch1 beyond frame");
    linearMode = 1'b0; mLin = 0;
    wr(8'h80 | 8'd8); wr(8'hC0 | 8'd5);
    runFrame(1'b1, 301, "R9 companded ch1 slot 8");
    wr(8'h80 | 8'd1); wr(8'hC0 | 8'd40);
    runFrame(1'b1, 302, "R9 companded ch2 slot 40");

    // R3, R4: stored slots ignored while disabled, then restored
    wr(8'h80 | 8'd5);
    wr(8'h40 | 8'd6);
    runFrame(1'b1, 303, "R3 R4 custom disabled");
    wr(8'hC0 | 8'd6);
    runFrame(1'b1, 304, "R3 R4 custom re-enabled");
    wr(8'h80 | 8'd3);
    runFrame(1'b1, 305, "R3 only ch1 rewritten");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule